// File: doc/BRIEF.md
# Serial Configuration Master Controller

This block loads a programmable target from a serial bitstream held in an on-chip memory. After reset it holds an open-drain status line low for a settling delay. It then samples a chip-select input to choose its role. In master role it reads the bitstream word by word through a synchronous read port. It shifts the bits out least-significant first on a data pin and generates a divided configuration clock alongside. In slave role it leaves both pins undriven and does nothing further.

The chip-select input is wired to the target's "configured" signal, so it has two uses. It chooses the role once, when the settling delay ends. From then on it reports whether the target has finished. The target finishing early is a fault. So is the target not finishing within a fixed number of clock periods after the last bit. On a fault the block pulls the status line low. With the restart option set, it holds the line low for a minimum pulse and then starts again from the first word. With the option clear, it stays in the fault state.

Top module: `cfg_serial_master`

## Requirements
- R1: While `rst` is high, `oe_low_o` is 1 and `busy_o`, `done_o`, `err_o` and `sclk_o` are 0. After `rst` falls, `oe_low_o` stays 1 through the first POR_CYCLES-1 rising clock edges and is 0 after edge POR_CYCLES.
- R2: If `sel_n_i` is 1 on the clock edge that follows the end of the delay, the block enters slave role and stays there until reset. In slave role: `slave_o` is 1, `sclk_oe_o` and `sdata_oe_o` are 0, `sclk_o` does not toggle, `mem_rd_o` stays 0 and `busy_o` is 0.
- R3: In master role, words are read starting at address 0 and counting up, with one cycle of read latency. Bit k of the stream is bit (k mod WORD_W) of word k/WORD_W. Exactly BITS bits are presented, and each is valid at a rising edge of `sclk_o`.
- R4: While bits are moving, `sclk_o` has a period of CLK_DIV system clocks and is high for CLK_DIV/2 of them.
- R5: `sdata_o` changes only together with a falling edge of `sclk_o`, so it is stable the whole time `sclk_o` is high.
- R6: If `sel_n_i` is 1 before the last bit's rising edge, `err_o` and `oe_low_o` are 1 one clock later.
- R7: If `sel_n_i` goes to 1 after the last bit and before the timeout, `done_o` is 1 one clock later. At that point `busy_o`, `err_o` and `oe_low_o` are 0, and `sclk_o` then stays 0 while still driven.
- R8: If `sel_n_i` stays 0 after the last bit, `err_o` rises one clock after the DONE_WAIT-th further rising edge of `sclk_o`, with `oe_low_o` 1.
- R9: With `restart_en_i` at 1, a fault holds `oe_low_o` at 1 for exactly ERR_PULSE*CLK_DIV clocks. The block then releases the line, samples the role again and resends the stream from word 0.
- R10: With `restart_en_i` at 0, a fault keeps `err_o` and `oe_low_o` at 1 indefinitely.
- R11: `busy_o` is 1 throughout fetching, shifting and waiting for the target to finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| restart_en_i | input | 1 | Restart automatically after a fault |
| sel_n_i | input | 1 | Role select at delay end, then the target's configured flag |
| mem_rdata_i | input | WORD_W | Read data, valid the cycle after the request |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Memory word address |
| oe_low_o | output | 1 | Drive the open-drain status line low |
| sclk_o | output | 1 | Configuration clock |
| sclk_oe_o | output | 1 | Configuration clock driver enable |
| sdata_o | output | 1 | Serial configuration data |
| sdata_oe_o | output | 1 | Serial data driver enable |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Target reported successful configuration |
| err_o | output | 1 | Configuration fault |
| slave_o | output | 1 | Slave role selected |

## Verification
Every response to `sel_n_i` shows one clock after the edge that samples it. The bench drives that input on a falling edge and reads the status on the next falling edge. Delay, fault-pulse and timeout lengths are checked by counting falling-edge samples from a known edge: POR_CYCLES edges after reset release, ERR_PULSE*CLK_DIV samples of a low status line, and DONE_WAIT rises of `sclk_o` before `err_o`. Data bits are compared at the first sample after each rising edge of `sclk_o`, against words computed arithmetically from their address. Each bit is then held and compared on every sample until the following fall.

// File: rtl/cfg_master_pkg.sv
`timescale 1ns/1ps
package cfg_master_pkg;
   typedef enum logic [2:0] {
      ST_POR,
      ST_SAMPLE,
      ST_SLAVE,
      ST_PREP,
      ST_SHIFT,
      ST_WAIT,
      ST_DONE,
      ST_ERR
   } cfg_state_e;
endpackage

// File: rtl/cfg_wait_ctr.sv
`timescale 1ns/1ps
module cfg_wait_ctr #(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         dec_i,
   output logic         expired_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= RST_VAL;
      else if (load_i)
         cnt_q <= load_val_i;
      else if (dec_i && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_sclk_gen.sv
`timescale 1ns/1ps
module cfg_sclk_gen #(
   parameter int unsigned HALF = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic run_i,
   output logic sclk_o,
   output logic rise_o,
   output logic fall_o
);
   logic sclk_q;
   logic edge_due;

   if (HALF < 1) begin : g_bad_half
      $error("cfg_sclk_gen: HALF must be at least 1");
   end

   if (HALF == 1) begin : g_toggle
      assign edge_due = 1'b1;
      always_ff @(posedge clk) begin
         if (rst || !run_i) sclk_q <= 1'b0;
         else               sclk_q <= ~sclk_q;
      end
   end else begin : g_count
      localparam int unsigned CW = $clog2(HALF);
      logic [CW-1:0] cnt_q;
      assign edge_due = (cnt_q == CW'(HALF - 1));
      always_ff @(posedge clk) begin
         if (rst || !run_i) begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
         end else if (edge_due) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
         end else begin
            cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   assign sclk_o = sclk_q;
   assign rise_o = run_i && edge_due && !sclk_q;
   assign fall_o = run_i && edge_due && sclk_q;
endmodule

// File: rtl/cfg_bit_shifter.sv
`timescale 1ns/1ps
module cfg_bit_shifter #(
   parameter int unsigned WORD_W = 8,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic              advance_i,
   input  logic [WORD_W-1:0] mem_rdata_i,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              ready_o,
   output logic              sdata_o
);
   localparam int unsigned POS_W = $clog2(WORD_W);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_W - 1);

   logic [ADDR_W-1:0] addr_q;
   logic              rd_q, pend_q, first_q, ready_q, nxt_ok_q;
   logic [WORD_W-1:0] sh_q, nxt_q;
   logic [POS_W-1:0]  pos_q;

   if (WORD_W < 2) begin : g_bad_word
      $error("cfg_bit_shifter: WORD_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q   <= '0;
         rd_q     <= 1'b0;
         pend_q   <= 1'b0;
         first_q  <= 1'b0;
         ready_q  <= 1'b0;
         nxt_ok_q <= 1'b0;
         sh_q     <= '0;
         nxt_q    <= '0;
         pos_q    <= '0;
      end else begin
         rd_q   <= 1'b0;
         pend_q <= rd_q;
         if (start_i) begin
            addr_q   <= '0;
            rd_q     <= 1'b1;
            first_q  <= 1'b1;
            ready_q  <= 1'b0;
            nxt_ok_q <= 1'b0;
            pos_q    <= '0;
         end else begin
            if (pend_q) begin
               if (first_q) begin
                  sh_q    <= mem_rdata_i;
                  first_q <= 1'b0;
                  ready_q <= 1'b1;
                  rd_q    <= 1'b1;
                  addr_q  <= addr_q + 1'b1;
               end else begin
                  nxt_q    <= mem_rdata_i;
                  nxt_ok_q <= 1'b1;
               end
            end
            if (advance_i) begin
               if (pos_q == LAST_POS) begin
                  sh_q     <= nxt_q;
                  pos_q    <= '0;
                  nxt_ok_q <= 1'b0;
                  rd_q     <= 1'b1;
                  addr_q   <= addr_q + 1'b1;
               end else begin
                  sh_q  <= sh_q >> 1;
                  pos_q <= pos_q + 1'b1;
               end
            end
         end
      end
   end

   // A word boundary may only be crossed once the next word has arrived.
   assert_prefetch_ready_R3: assert property (@(posedge clk) disable iff (rst)
      (advance_i && pos_q == LAST_POS) |-> nxt_ok_q);

   assign mem_rd_o   = rd_q;
   assign mem_addr_o = addr_q;
   assign ready_o    = ready_q;
   assign sdata_o    = sh_q[0];
endmodule

// File: rtl/cfg_serial_master.sv
`timescale 1ns/1ps
module cfg_serial_master import cfg_master_pkg::*; #(
   parameter int unsigned POR_CYCLES = 50_000_000,
   parameter int unsigned CLK_DIV    = 4,
   parameter int unsigned BITS       = 1_048_576,
   parameter int unsigned WORD_W     = 8,
   parameter int unsigned DONE_WAIT  = 16,
   parameter int unsigned ERR_PULSE  = 8,
   localparam int unsigned WORDS     = (BITS + WORD_W - 1) / WORD_W,
   localparam int unsigned ADDR_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              restart_en_i,
   input  logic              sel_n_i,
   input  logic [WORD_W-1:0] mem_rdata_i,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              oe_low_o,
   output logic              sclk_o,
   output logic              sclk_oe_o,
   output logic              sdata_o,
   output logic              sdata_oe_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic              slave_o
);
   localparam int unsigned HALF    = CLK_DIV / 2;
   localparam int unsigned BIT_W   = $clog2(BITS);
   localparam int unsigned POR_W   = $clog2(POR_CYCLES + 1);
   localparam int unsigned ERR_CYC = ERR_PULSE * CLK_DIV;
   localparam int unsigned ERR_W   = $clog2(ERR_CYC + 1);
   localparam int unsigned WAIT_W  = $clog2(DONE_WAIT + 1);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS - 1);

   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("cfg_serial_master: CLK_DIV must be even and at least 2");
   end
   if (POR_CYCLES < 2) begin : g_bad_por
      $error("cfg_serial_master: POR_CYCLES must be at least 2");
   end
   if (BITS < 2) begin : g_bad_bits
      $error("cfg_serial_master: BITS must be at least 2");
   end
   if (DONE_WAIT < 1 || ERR_PULSE < 1) begin : g_bad_wait
      $error("cfg_serial_master: DONE_WAIT and ERR_PULSE must be at least 1");
   end

   cfg_state_e       state_q, state_d;
   logic [BIT_W-1:0] bit_idx_q;
   logic por_exp, err_exp, wait_exp;
   logic rise, fall, run, start, advance, ready;
   logic err_load, wait_load;

   // ---------------- sequencing ----------------
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_POR:    if (por_exp) state_d = ST_SAMPLE;
         ST_SAMPLE: state_d = sel_n_i ? ST_SLAVE : ST_PREP;
         ST_SLAVE:  state_d = ST_SLAVE;
         ST_PREP: begin
            if (sel_n_i)    state_d = ST_ERR;
            else if (ready) state_d = ST_SHIFT;
         end
         ST_SHIFT: begin
            if (sel_n_i)                           state_d = ST_ERR;
            else if (rise && bit_idx_q == LAST_BIT) state_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (sel_n_i)       state_d = ST_DONE;
            else if (wait_exp) state_d = ST_ERR;
         end
         ST_DONE:   state_d = ST_DONE;
         ST_ERR:    if (err_exp && restart_en_i) state_d = ST_SAMPLE;
         default:   state_d = ST_POR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_POR;
      else     state_q <= state_d;
   end

   assign start     = (state_q == ST_SAMPLE) && !sel_n_i;
   assign run       = (state_q == ST_SHIFT) || (state_q == ST_WAIT);
   assign advance   = fall && (state_q == ST_SHIFT);
   assign err_load  = (state_d == ST_ERR) && (state_q != ST_ERR);
   assign wait_load = (state_q == ST_SHIFT) && (state_d == ST_WAIT);

   always_ff @(posedge clk) begin
      if (rst || start) bit_idx_q <= '0;
      else if (advance) bit_idx_q <= bit_idx_q + 1'b1;
   end

   // ---------------- timers ----------------
   cfg_wait_ctr #(.W(POR_W), .RST_VAL(POR_W'(POR_CYCLES - 1))) u_por_ctr (
      .clk(clk), .rst(rst), .load_i(1'b0), .load_val_i('0),
      .dec_i(state_q == ST_POR), .expired_o(por_exp));

   cfg_wait_ctr #(.W(ERR_W), .RST_VAL('0)) u_err_ctr (
      .clk(clk), .rst(rst), .load_i(err_load), .load_val_i(ERR_W'(ERR_CYC - 1)),
      .dec_i(state_q == ST_ERR), .expired_o(err_exp));

   cfg_wait_ctr #(.W(WAIT_W), .RST_VAL('0)) u_wait_ctr (
      .clk(clk), .rst(rst), .load_i(wait_load), .load_val_i(WAIT_W'(DONE_WAIT)),
      .dec_i(rise && state_q == ST_WAIT), .expired_o(wait_exp));

   // ---------------- clock and data path ----------------
   cfg_sclk_gen #(.HALF(HALF)) u_sclk (
      .clk(clk), .rst(rst), .run_i(run),
      .sclk_o(sclk_o), .rise_o(rise), .fall_o(fall));

   cfg_bit_shifter #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_shift (
      .clk(clk), .rst(rst), .start_i(start), .advance_i(advance),
      .mem_rdata_i(mem_rdata_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
      .ready_o(ready), .sdata_o(sdata_o));

   // ---------------- pins and status ----------------
   assign oe_low_o   = (state_q == ST_POR) || (state_q == ST_ERR);
   assign sclk_oe_o  = (state_q != ST_SLAVE);
   assign sdata_oe_o = (state_q != ST_SLAVE);
   assign busy_o     = (state_q == ST_PREP) || (state_q == ST_SHIFT) || (state_q == ST_WAIT);
   assign done_o     = (state_q == ST_DONE);
   assign err_o      = (state_q == ST_ERR);
   assign slave_o    = (state_q == ST_SLAVE);

   // ---------------- assertions ----------------
   assert_slave_quiet_R2: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_SLAVE) |-> (!mem_rd_o && !sclk_o));

   assert_bit_range_R3: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_SHIFT) |-> (bit_idx_q <= LAST_BIT));

   assert_data_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

   assert_idle_clock_R7: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_DONE && $past(state_q) == ST_DONE) |-> !sclk_o);

   assert_timeout_cause_R8: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_ERR && $past(state_q) == ST_WAIT) |-> ($past(wait_exp) && !$past(sel_n_i)));

   assert_min_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_SAMPLE && $past(state_q) == ST_ERR) |-> $past(err_exp));

   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_ERR && !restart_en_i) |=> (state_q == ST_ERR));
endmodule

// File: tb/cfg_serial_master_bench.sv
`timescale 1ns/1ps
module cfg_serial_master_bench;
   localparam int POR = 12;
   localparam int DIV = 4;
   localparam int NB  = 20;
   localparam int WW  = 8;
   localparam int DW  = 16;
   localparam int EP  = 8;
   localparam int AW  = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic restart_en = 1'b0;
   logic sel_n = 1'b0;
   logic [WW-1:0] mem_rdata = '0;
   logic mem_rd, oe_low, sclk, sclk_oe, sdata, sdata_oe, busy, done, err, slave;
   logic [AW-1:0] mem_addr;

   int checks = 0;
   int fails  = 0;
   int xidx   = 0;
   bit prev_sclk = 1'b0;

   always #2 clk = ~clk;

   cfg_serial_master #(.POR_CYCLES(POR), .CLK_DIV(DIV), .BITS(NB), .WORD_W(WW),
                       .DONE_WAIT(DW), .ERR_PULSE(EP)) u_cfg_serial_master (
      .clk(clk), .rst(rst), .restart_en_i(restart_en), .sel_n_i(sel_n),
      .mem_rdata_i(mem_rdata), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
      .oe_low_o(oe_low), .sclk_o(sclk), .sclk_oe_o(sclk_oe), .sdata_o(sdata),
      .sdata_oe_o(sdata_oe), .busy_o(busy), .done_o(done), .err_o(err), .slave_o(slave));

   function automatic logic [WW-1:0] word_at(input int a);
      return WW'((a * 37 + 91) & 255);
   endfunction

   function automatic logic bit_at(input int i);
      logic [WW-1:0] w;
      w = word_at(i / WW);
      return w[i % WW];
   endfunction

   // synchronous memory, one cycle read latency
   always @(posedge clk) if (mem_rd) mem_rdata <= word_at(int'(mem_addr));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(output bit rose);
      @(negedge clk);
      rose = sclk && !prev_sclk;
      prev_sclk = sclk;
   endtask

   task automatic do_reset(input logic seln, input logic ren);
      @(negedge clk);
      rst = 1'b1; sel_n = seln; restart_en = ren;
      repeat (3) @(negedge clk);
      chk(oe_low == 1'b1, "R1 oe_low in reset", int'(oe_low), 1);
      chk({busy, done, err, sclk} == 4'b0, "R1 status in reset", int'({busy, done, err, sclk}), 0);
      rst = 1'b0;
      prev_sclk = 1'b0;
      repeat (POR - 1) @(posedge clk);
      @(negedge clk);
      chk(oe_low == 1'b1, "R1 oe_low before delay end", int'(oe_low), 1);
      @(negedge clk);
      chk(oe_low == 1'b0, "R1 oe_low released", int'(oe_low), 0);
   endtask

   task automatic shift_in(input int nbits, input string tag);
      int seen = 0, since = 0, hi = 0, guard = 0;
      bit have = 1'b0, rose, was;
      logic held = 1'b0;
      while (seen < nbits && guard < 5000) begin
         was = prev_sclk;
         tick(rose);
         guard++; since++;
         if (rose) begin
            chk(sdata === bit_at(xidx), tag, int'(sdata), int'(bit_at(xidx)));
            if (have) chk(since == DIV, "R4 period", since, DIV);
            chk(busy == 1'b1, "R11 busy while shifting", int'(busy), 1);
            have = 1'b1; since = 0; hi = 1; held = sdata;
            xidx++; seen++;
         end else if (sclk && was) begin
            hi++;
            chk(sdata === held, "R5 data stable while high", int'(sdata), int'(held));
         end else if (!sclk && was) begin
            chk(hi == DIV / 2, "R4 high time", hi, DIV / 2);
         end
      end
      chk(seen == nbits, "R3 bits delivered", seen, nbits);
   endtask

   initial begin
      bit rose;
      int n, bad;

      // ---- success: done inside the window ----
      do_reset(1'b0, 1'b0);
      xidx = 0;
      shift_in(NB, "R3 bit value");
      n = 0;
      while (n < 3) begin
         tick(rose);
         if (rose) n++;
      end
      chk(err == 1'b0 && busy == 1'b1, "R11 busy in wait", int'({err, busy}), 1);
      sel_n = 1'b1;
      tick(rose);
      chk(done == 1'b1, "R7 done", int'(done), 1);
      chk({busy, err, oe_low} == 3'b0, "R7 status at done", int'({busy, err, oe_low}), 0);
      repeat (5) tick(rose);
      chk(sclk == 1'b0 && sclk_oe == 1'b1, "R7 clock idle low", int'({sclk, sclk_oe}), 1);

      // ---- timeout, no restart ----
      do_reset(1'b0, 1'b0);
      xidx = 0;
      shift_in(NB, "R3 bit value");
      n = 0; bad = 0;
      while (!err && bad < 2000) begin
         tick(rose);
         bad++;
         if (rose) n++;
      end
      chk(n == DW, "R8 rises before timeout", n, DW);
      chk(oe_low == 1'b1, "R8 oe_low on timeout", int'(oe_low), 1);
      bad = 0;
      repeat (200) begin
         tick(rose);
         if (!err || !oe_low || sclk) bad++;
      end
      chk(bad == 0, "R10 fault held", bad, 0);

      // ---- early done, restart ----
      do_reset(1'b0, 1'b1);
      xidx = 0;
      shift_in(7, "R3 bit value");
      sel_n = 1'b1;
      tick(rose);
      chk(err == 1'b1 && oe_low == 1'b1, "R6 early done fault", int'({err, oe_low}), 3);
      chk(busy == 1'b0, "R6 busy cleared", int'(busy), 0);
      sel_n = 1'b0;
      n = 1; bad = 0;
      while (oe_low && bad < 2000) begin
         tick(rose);
         bad++;
         if (oe_low) n++;
      end
      chk(n == EP * DIV, "R9 fault pulse length", n, EP * DIV);
      chk(err == 1'b0, "R9 fault cleared on restart", int'(err), 0);
      xidx = 0;
      shift_in(NB, "R9 resend from word 0");
      rose = 1'b0;
      while (!rose) tick(rose);
      sel_n = 1'b1;
      tick(rose);
      chk(done == 1'b1, "R7 done after restart", int'(done), 1);

      // ---- slave role ----
      do_reset(1'b1, 1'b0);
      tick(rose);
      chk(slave == 1'b1, "R2 slave selected", int'(slave), 1);
      bad = 0;
      repeat (60) begin
         tick(rose);
         if (mem_rd || sclk_oe || sdata_oe || sclk || busy || !slave) bad++;
      end
      chk(bad == 0, "R2 slave quiet", bad, 0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule